// File: doc/BRIEF.md
# Digit-Serial Redundant Montgomery Multiplier

The block computes a Montgomery product X·Y·2^(−R·K) mod M. It works on K-digit numbers in base 2^R. X and Y are plain binary operands with X < M. Y is consumed one digit per step, starting with the least significant digit. The running sum S is kept in a redundant form. Each digit slot is R+2 bits wide and holds R principal bits and two redundant bits. Carries move at most one digit per step, so no carry ever crosses the whole word.

For each step the block forms S + X·y_j. It derives a quotient digit q from the low R bits of that sum and a supplied constant. It then reads q·M from a synchronous lookup table indexed by q, adds it in, and drops the low digit, which is known to be zero. Every Y digit costs two cycles: one for the multiply-accumulate and table read, and one for the fold and shift. After the last step, a correction pass checks only the redundant bits of the top digit. When they are 01, the pass adds the supplied constant 2^(R·K) − M, which subtracts M. No full comparison against M is made.

The modulus is held fixed across many products, so M itself is never an input. The owner precomputes −M^(−1) mod 2^R and 2^(R·K) − M, and loads the q·M table through a write port while the block is idle.

Top module: `mm_redundant_montmul`

## Requirements
- R1: While rst_n is low and after it is released, busy_o and done_o are 0 and res_o is all zeros.
- R2: res_o is a K-digit redundant number. Digit i sits at bits [(R+2)·i+R+1 : (R+2)·i] and carries weight 2^(R·i). Its value is congruent to X·Y·2^(−R·K) mod M. X is taken from x_i and Y from y_i at start, both plain K·R-bit binary with X < M. minv_i = (−M^(−1)) mod 2^R and corr_i = 2^(R·K) − M are also taken at start.
- R3: When done_o is 1, the two redundant bits of the top result digit (bits K·(R+2)−1 and K·(R+2)−2) are 00.
- R4: A start seen in idle sets busy_o on the next edge. done_o rises exactly 2·K+1 clock edges after the edge that accepted start, and busy_o falls on that same edge.
- R5: done_o is high for exactly one cycle. res_o then holds its value until the end of the next operation.
- R6: start is ignored while busy_o is 1. Changing start, x_i or y_i mid-operation changes neither the result nor the latency.
- R7: The result value, summed from its digits, is less than 2·M.
- R8: Table entry q, written through tbl_we_i, tbl_addr_i and tbl_data_i while the block is idle, holds q·M as a (K+1)-digit plain number with digit i at bits [R·i+R−1 : R·i]. Reloading the table with another modulus makes later results follow that modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a product (accepted only when idle) |
| x_i | input | K·R | Multiplicand X, plain binary, X < M |
| y_i | input | K·R | Multiplier Y, plain binary |
| minv_i | input | R | Precomputed (−M^(−1)) mod 2^R |
| corr_i | input | K·R | Precomputed 2^(R·K) − M |
| tbl_we_i | input | 1 | Write strobe for the q·M table |
| tbl_addr_i | input | R | Table write address (q) |
| tbl_data_i | input | (K+1)·R | Table write data (q·M) |
| busy_o | output | 1 | Product in progress |
| done_o | output | 1 | One-cycle pulse when res_o is updated |
| res_o | output | K·(R+2) | Result in redundant digit form |

## Verification
A wrong quotient digit or a mismatched table word leaves a nonzero low digit at the fold. That fault does not stay local. It shifts a wrong value into every later step, so the result's residue mod M is wrong at the very next done pulse, 2·K+1 cycles after start. A fault in the digit carries or the top-digit correction shows at that same pulse in one of two ways. The result reaches 2·M or more, or the top redundant bits are nonzero. A sequencing fault shows first as a latency other than 2·K+1, or as a done pulse longer than one cycle.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_FOLD = 2'd2,
        ST_FIX  = 2'd3
    } mm_state_e;

endpackage

// File: rtl/mm_digit_mac.sv
// Multiply-accumulate phase of one step: acc = S + X*y split into per-digit
// sums with no block carry, plus the quotient digit for this step.
module mm_digit_mac #(
    parameter int R_BITS = 8,
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*(R_BITS+2)-1:0]     sum_i,
    input  logic [DIGITS*R_BITS-1:0]         xop_i,
    input  logic [R_BITS-1:0]                ydig_i,
    input  logic [R_BITS-1:0]                minv_i,
    output logic [(DIGITS+1)*(R_BITS+3)-1:0] acc_o,
    output logic [R_BITS-1:0]                quot_o
);
    localparam int DW = R_BITS + 2;
    localparam int AW = R_BITS + 3;
    localparam int PW = 2 * R_BITS;

    logic [PW-1:0] prod [DIGITS];

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_prod
        assign prod[gi] = PW'(xop_i[gi*R_BITS +: R_BITS]) * PW'(ydig_i);
    end

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_acc
        if (gi == 0) begin : g_low
            assign acc_o[gi*AW +: AW] = AW'(sum_i[gi*DW +: DW])
                                      + AW'(prod[gi][R_BITS-1:0]);
        end else begin : g_mid
            assign acc_o[gi*AW +: AW] = AW'(sum_i[gi*DW +: DW])
                                      + AW'(prod[gi][R_BITS-1:0])
                                      + AW'(prod[gi-1][PW-1:R_BITS]);
        end
    end

    assign acc_o[DIGITS*AW +: AW] = AW'(prod[DIGITS-1][PW-1:R_BITS]);

    // Quotient digit from the low principal bits of the accumulated sum.
    assign quot_o = acc_o[R_BITS-1:0] * minv_i;

endmodule

// File: rtl/mm_qm_table.sv
// Preloaded q*M table with registered (synchronous) read.
module mm_qm_table #(
    parameter int R_BITS = 8,
    parameter int DIGITS = 4
) (
    input  logic                         clk,
    input  logic                         wr_en_i,
    input  logic [R_BITS-1:0]            wr_addr_i,
    input  logic [(DIGITS+1)*R_BITS-1:0] wr_data_i,
    input  logic [R_BITS-1:0]            rd_addr_i,
    output logic [(DIGITS+1)*R_BITS-1:0] rd_data_o
);
    localparam int DEPTH = 1 << R_BITS;
    localparam int EW    = (DIGITS + 1) * R_BITS;

    logic [EW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
        rd_data_o <= mem_q[rd_addr_i];
    end

endmodule

// File: rtl/mm_fold.sv
// Fold phase: add q*M, pass digit carries one position up, drop the low digit.
module mm_fold #(
    parameter int R_BITS = 8,
    parameter int DIGITS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             chk_en_i,
    input  logic [(DIGITS+1)*(R_BITS+3)-1:0] acc_i,
    input  logic [(DIGITS+1)*R_BITS-1:0]     qm_i,
    output logic [DIGITS*(R_BITS+2)-1:0]     sum_o
);
    localparam int DW = R_BITS + 2;
    localparam int AW = R_BITS + 3;
    localparam int CW = AW - R_BITS;

    logic [AW-1:0] u    [DIGITS+1];
    logic [CW-1:0] cy   [DIGITS];
    logic [AW-1:0] top_full;

    for (genvar gi = 0; gi <= DIGITS; gi++) begin : g_add
        assign u[gi] = acc_i[gi*AW +: AW] + AW'(qm_i[gi*R_BITS +: R_BITS]);
    end

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_cy
        assign cy[gi] = u[gi][AW-1:R_BITS];
    end

    for (genvar gi = 0; gi < DIGITS - 1; gi++) begin : g_shift
        assign sum_o[gi*DW +: DW] = DW'(u[gi+1][R_BITS-1:0]) + DW'(cy[gi]);
    end

    assign top_full = u[DIGITS] + AW'(cy[DIGITS-1]);
    assign sum_o[(DIGITS-1)*DW +: DW] = top_full[DW-1:0];

    // R2
    low_digit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en_i |-> (u[0][R_BITS-1:0] == '0));

    // R7
    top_digit_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en_i |-> (top_full[AW-1:DW] == '0));

endmodule

// File: rtl/mm_fixup.sv
// Final correction: when the top digit's redundant bits read 01, add
// 2^(R*K) - M digit-wise and drop the 2^(R*K) weight from the top digit.
module mm_fixup #(
    parameter int R_BITS = 8,
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*(R_BITS+2)-1:0] sum_i,
    input  logic [DIGITS*R_BITS-1:0]     corr_i,
    output logic [DIGITS*(R_BITS+2)-1:0] res_o
);
    localparam int DW = R_BITS + 2;
    localparam int CW = DW - R_BITS;

    logic [DW-1:0] v  [DIGITS];
    logic [CW-1:0] cy [DIGITS-1];
    logic [DIGITS*DW-1:0] fixed;
    logic needs_fix;

    assign needs_fix = (sum_i[DIGITS*DW-1 -: CW] == CW'(1));

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_add
        assign v[gi] = sum_i[gi*DW +: DW] + DW'(corr_i[gi*R_BITS +: R_BITS]);
    end

    for (genvar gi = 0; gi < DIGITS - 1; gi++) begin : g_cy
        assign cy[gi] = v[gi][DW-1:R_BITS];
    end

    for (genvar gi = 0; gi < DIGITS - 1; gi++) begin : g_dig
        if (gi == 0) begin : g_low
            assign fixed[gi*DW +: DW] = DW'(v[gi][R_BITS-1:0]);
        end else begin : g_mid
            assign fixed[gi*DW +: DW] = DW'(v[gi][R_BITS-1:0]) + DW'(cy[gi-1]);
        end
    end

    assign fixed[(DIGITS-1)*DW +: DW] = v[DIGITS-1] + DW'(cy[DIGITS-2])
                                      - DW'(1 << R_BITS);

    assign res_o = needs_fix ? fixed : sum_i;

endmodule

// File: rtl/mm_redundant_montmul.sv
module mm_redundant_montmul
    import mm_pkg::*;
#(
    parameter int R_BITS = 8,
    parameter int DIGITS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [DIGITS*R_BITS-1:0]     x_i,
    input  logic [DIGITS*R_BITS-1:0]     y_i,
    input  logic [R_BITS-1:0]            minv_i,
    input  logic [DIGITS*R_BITS-1:0]     corr_i,
    input  logic                         tbl_we_i,
    input  logic [R_BITS-1:0]            tbl_addr_i,
    input  logic [(DIGITS+1)*R_BITS-1:0] tbl_data_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [DIGITS*(R_BITS+2)-1:0] res_o
);
    localparam int DW  = R_BITS + 2;
    localparam int AW  = R_BITS + 3;
    localparam int NW  = DIGITS * R_BITS;
    localparam int SW  = DIGITS * DW;
    localparam int ACW = (DIGITS + 1) * AW;
    localparam int QW  = (DIGITS + 1) * R_BITS;
    localparam int CNW = $clog2(DIGITS + 1);

    typedef struct packed {
        mm_state_e          st;
        logic [CNW-1:0]     cnt;
        logic [SW-1:0]      s;
        logic [ACW-1:0]     acc;
        logic [NW-1:0]      xr;
        logic [NW-1:0]      yr;
        logic [NW-1:0]      corr;
        logic [R_BITS-1:0]  minv;
        logic [SW-1:0]      res;
        logic               done;
    } regs_t;

    regs_t r_d, r_q;

    logic [ACW-1:0]    mac_acc;
    logic [R_BITS-1:0] mac_quot;
    logic [QW-1:0]     qm_word;
    logic [SW-1:0]     fold_sum;
    logic [SW-1:0]     fix_res;

    mm_digit_mac #(.R_BITS(R_BITS), .DIGITS(DIGITS)) mac_i (
        .sum_i  (r_q.s),
        .xop_i  (r_q.xr),
        .ydig_i (r_q.yr[R_BITS-1:0]),
        .minv_i (r_q.minv),
        .acc_o  (mac_acc),
        .quot_o (mac_quot)
    );

    mm_qm_table #(.R_BITS(R_BITS), .DIGITS(DIGITS)) table_i (
        .clk       (clk),
        .wr_en_i   (tbl_we_i),
        .wr_addr_i (tbl_addr_i),
        .wr_data_i (tbl_data_i),
        .rd_addr_i (mac_quot),
        .rd_data_o (qm_word)
    );

    mm_fold #(.R_BITS(R_BITS), .DIGITS(DIGITS)) fold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_en_i (r_q.st == ST_FOLD),
        .acc_i    (r_q.acc),
        .qm_i     (qm_word),
        .sum_o    (fold_sum)
    );

    mm_fixup #(.R_BITS(R_BITS), .DIGITS(DIGITS)) fixup_i (
        .sum_i  (r_q.s),
        .corr_i (r_q.corr),
        .res_o  (fix_res)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_MAC;
                    r_d.cnt  = '0;
                    r_d.s    = '0;
                    r_d.xr   = x_i;
                    r_d.yr   = y_i;
                    r_d.corr = corr_i;
                    r_d.minv = minv_i;
                end
            end
            ST_MAC: begin
                r_d.acc = mac_acc;
                r_d.st  = ST_FOLD;
            end
            ST_FOLD: begin
                r_d.s  = fold_sum;
                r_d.yr = r_q.yr >> R_BITS;
                if (r_q.cnt == CNW'(DIGITS - 1)) begin
                    r_d.st = ST_FIX;
                end else begin
                    r_d.cnt = r_q.cnt + CNW'(1);
                    r_d.st  = ST_MAC;
                end
            end
            ST_FIX: begin
                r_d.res  = fix_res;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st != ST_IDLE);
    assign done_o = r_q.done;
    assign res_o  = r_q.res;

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R4
    mac_then_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MAC) |=> (r_q.st == ST_FOLD));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_FIX) |=> $stable(res_o));

    // R3
    top_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (res_o[SW-1 -: 2] == 2'b00));

    // R7
    prefix_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FIX) |-> (r_q.s[SW-1] == 1'b0));

endmodule

// File: tb/mm_redundant_montmul_tb.sv
module mm_redundant_montmul_tb_top;
    localparam int R  = 8;
    localparam int K  = 4;
    localparam int DW = R + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [K*R-1:0] x_i = '0, y_i = '0, corr_i = '0;
    logic [R-1:0] minv_i = '0;
    logic tbl_we_i = 1'b0;
    logic [R-1:0] tbl_addr_i = '0;
    logic [(K+1)*R-1:0] tbl_data_i = '0;
    logic busy_o, done_o;
    logic [K*DW-1:0] res_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    mm_redundant_montmul #(.R_BITS(R), .DIGITS(K)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i), .y_i(y_i),
        .minv_i(minv_i), .corr_i(corr_i), .tbl_we_i(tbl_we_i),
        .tbl_addr_i(tbl_addr_i), .tbl_data_i(tbl_data_i),
        .busy_o(busy_o), .done_o(done_o), .res_o(res_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_mm(input logic [31:0] x, input logic [31:0] y,
                                           input logic [31:0] m);
        logic [63:0] v;
        v = ({32'b0, x} * {32'b0, y}) % {32'b0, m};
        for (int i = 0; i < K*R; i++) begin
            if (v[0]) v = v + {32'b0, m};
            v = v >> 1;
        end
        return v[31:0];
    endfunction

    function automatic logic [7:0] minv_of(input logic [31:0] m);
        logic [15:0] p;
        for (int t = 0; t < 256; t++) begin
            p = {8'b0, m[7:0]} * 16'(t);
            if (p[7:0] == 8'hFF) return 8'(t);
        end
        return 8'h00;
    endfunction

    function automatic logic [63:0] value_of(input logic [K*DW-1:0] r);
        logic [63:0] acc;
        acc = '0;
        for (int i = 0; i < K; i++) acc = acc + ({54'b0, r[i*DW +: DW]} << (R*i));
        return acc;
    endfunction

    task automatic load_table(input logic [31:0] m);
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            tbl_we_i   = 1'b1;
            tbl_addr_i = 8'(a);
            tbl_data_i = 40'(a) * {8'b0, m};
        end
        @(negedge clk);
        tbl_we_i = 1'b0;
    endtask

    task automatic run_op(input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] m, input bit poke, input string tag);
        logic [31:0] exp;
        logic [63:0] val;
        logic [32:0] c;
        logic [K*DW-1:0] held;
        int lat;
        exp = ref_mm(x, y, m);
        c = 33'h1_0000_0000 - {1'b0, m};
        @(negedge clk);
        x_i = x; y_i = y; minv_i = minv_of(m); corr_i = c[31:0]; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R4 busy after start", 64'(busy_o), 64'd1);
        lat = 0;
        while (!done_o && lat < 50) begin
            if (poke && lat == 2) begin start_i = 1'b1; x_i = ~x; y_i = ~y; end
            if (lat == 5) start_i = 1'b0;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(lat == 2*K+1, "R4 latency", 64'(lat), 64'(2*K+1));
        check(busy_o == 1'b0, "R4 busy low at done", 64'(busy_o), 64'd0);
        val = value_of(res_o);
        check((val % {32'b0, m}) == {32'b0, exp}, poke ? "R6 result after mid-run start" : tag,
              val % {32'b0, m}, {32'b0, exp});
        check(val < 2 * {32'b0, m}, "R7 result below 2M", val, 2 * {32'b0, m});
        check(res_o[K*DW-1 -: 2] == 2'b00, "R3 top redundant bits", 64'(res_o[K*DW-1 -: 2]), 64'd0);
        held = res_o;
        @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R5 done one cycle", 64'(done_o), 64'd0);
        repeat (3) @(negedge clk);
        check(res_o == held, "R5 result held", 64'(res_o), 64'(held));
    endtask

    initial begin
        #4_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] m, x, y;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy_o == 1'b0, "R1 busy in reset", 64'(busy_o), 64'd0);
        check(done_o == 1'b0, "R1 done in reset", 64'(done_o), 64'd0);
        check(res_o == '0, "R1 result in reset", 64'(res_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && res_o == '0, "R1 idle after reset", 64'(busy_o), 64'd0);

        // Large random modulus
        m = $urandom | 32'h8000_0001;
        load_table(m);
        run_op(32'd0, $urandom, m, 1'b0, "R2 zero X");
        run_op(m - 1, 32'hFFFF_FFFF, m, 1'b0, "R2 max operands");
        run_op(32'd1, 32'd1, m, 1'b0, "R2 unit operands");
        run_op($urandom % m, $urandom, m, 1'b1, "R6");
        for (int i = 0; i < 12; i++) begin
            x = $urandom % m;
            y = $urandom;
            run_op(x, y, m, 1'b0, "R2 random");
        end

        // R8 reload with the all-ones modulus
        m = 32'hFFFF_FFFF;
        load_table(m);
        run_op(m - 1, m - 1, m, 1'b0, "R8 reload all-ones modulus");
        for (int i = 0; i < 8; i++) begin
            x = $urandom % m;
            run_op(x, $urandom, m, 1'b0, "R2 random all-ones modulus");
        end

        // R8 reload with a small modulus
        m = 32'h0000_0F0B;
        load_table(m);
        run_op(m - 1, 32'hFFFF_FFFF, m, 1'b0, "R8 reload small modulus");
        for (int i = 0; i < 8; i++) begin
            x = $urandom % m;
            run_op(x, $urandom, m, 1'b0, "R2 random small modulus");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule